// File: doc/BRIEF.md
# Sign-Scattered Bit-Plane Stream Parser

This block turns a code-block that was stored plane by plane back into per-coefficient results for a bit-plane coder. Each plane is held as its own packed bit stream. A coefficient's sign bit is stored only once, directly behind the first 1 of that coefficient's magnitude. The parser walks the requested planes from the highest plane down to a lower cut-off plane. Within each plane it visits coefficients 0 to N-1 in scan order. For each coefficient it emits the magnitude bit of the current plane and, when that bit makes the coefficient significant for the first time, the sign recovered from the stream.

Words are pulled through a valid/ready input. The plain output `req_plane` names the plane whose next word the supplier must present. The block never asks for planes below the cut-off, so truncated planes cost no memory traffic. It keeps one significance bit per coefficient, which is enough to tell a sign bit from the next magnitude bit.

Results leave through a valid/ready output register. While `out_valid` is high and `out_ready` is low, the result is held unchanged and parsing stops. Back-pressure on the input is only ever a wait: the supplier may hold `in_valid` low for any number of cycles. A word counts as consumed in the cycle where `in_valid` and `in_ready` are both high.

Top module: `bitplane_sign_parser`

## Requirements
- R1: After reset, `busy`, `in_ready` and `out_valid` are low.
- R2: A `start` pulse while idle begins a run. Results come out for every plane from `top_plane` down to `low_plane` inclusive, highest plane first. Within a plane, results come out for indices 0 to `coef_count`-1 in order. Each result carries its index and plane.
- R3: Stream bits are read least significant bit of a word first. The magnitude bit of a coefficient is the next unread bit of the current plane's stream.
- R4: When the magnitude bit is 1 and the coefficient had no 1 in any plane decoded earlier in the run, the following stream bit is its sign. That result has `out_sign_vld`=1 and `out_sign` equal to that bit (1 = negative).
- R5: When the coefficient was already significant, no sign bit is read. The result has `out_sign_vld`=0 and `out_sign`=0, and the next stream bit belongs to the next coefficient.
- R6: All significance state is cleared at each `start`, so a new run reports signs afresh.
- R7: A sign bit that would fall past the last bit of a word is taken from bit 0 of the next word of the same plane.
- R8: Each plane's stream begins at bit 0 of a new word. Bits left in a plane's last word after its final coefficient are discarded.
- R9: `req_plane` names the plane being decoded. Words are consumed only for planes in [`low_plane`, `top_plane`], and exactly ceil(bits of that plane / `WORD_W`) words are consumed per plane.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every result field is held.
- R11: `in_ready` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| top_plane | input | PLANE_W | Highest plane decoded (first) |
| low_plane | input | PLANE_W | Lowest plane decoded (truncation point) |
| coef_count | input | CNT_W | Coefficients per plane, 1 to MAX_COEF |
| busy | output | 1 | A run is in progress |
| req_plane | output | PLANE_W | Plane whose next word is wanted |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle |
| in_word | input | WORD_W | Next stream word of `req_plane` |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_mag | output | 1 | Magnitude bit in `out_plane` |
| out_sign_vld | output | 1 | This result carries the sign |
| out_sign | output | 1 | Sign, 1 = negative |
| out_index | output | IDX_W | Coefficient index in scan order |
| out_plane | output | PLANE_W | Plane of this result |

## Verification
The assertions check on every cycle that an output result is held while stalled, that a sign never comes without a magnitude 1, that no coefficient becomes significant twice in one run, and that the requested plane never rises during a run or drops below the cut-off. Only the bench's scenarios can show that the parsed bit positions are right. That covers a sign spilling into the next word, discarded tail bits, exact word counts per plane, and signs reappearing after a new start. To show these, the bench compares every result against streams it packs itself from random and crafted coefficients.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/sbd_sig_bits.sv
module sbd_sig_bits #(
  parameter int MAX_COEF = 64,
  localparam int IDX_W = $clog2(MAX_COEF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  logic [MAX_COEF-1:0] sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sig_q <= '0;
    else if (clr)    sig_q <= '0;
    else if (set_en) sig_q[set_idx] <= 1'b1;
  end

  assign rd_bit = sig_q[rd_idx];

  // R5
  no_double_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && (set_idx == rd_idx)) |-> !rd_bit);
endmodule

// File: rtl/sbd_out_stage.sv
module sbd_out_stage #(
  parameter int PLANE_W = 4,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               d_mag,
  input  logic               d_sv,
  input  logic               d_sgn,
  input  logic [IDX_W-1:0]   d_idx,
  input  logic [PLANE_W-1:0] d_plane,
  output logic               can_take,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_mag,
  output logic               out_sign_vld,
  output logic               out_sign,
  output logic [IDX_W-1:0]   out_index,
  output logic [PLANE_W-1:0] out_plane
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_mag      <= 1'b0;
      out_sign_vld <= 1'b0;
      out_sign     <= 1'b0;
      out_index    <= '0;
      out_plane    <= '0;
    end else if (load) begin
      out_valid    <= 1'b1;
      out_mag      <= d_mag;
      out_sign_vld <= d_sv;
      out_sign     <= d_sgn;
      out_index    <= d_idx;
      out_plane    <= d_plane;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid &&
      $stable({out_mag, out_sign_vld, out_sign, out_index, out_plane})));
  // R4
  sign_needs_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!out_sign_vld || out_mag));
endmodule

// File: rtl/bitplane_sign_parser.sv
module bitplane_sign_parser #(
  parameter int WORD_W   = 8,
  parameter int MAX_COEF = 64,
  parameter int PLANE_W  = 4,
  localparam int IDX_W = $clog2(MAX_COEF),
  localparam int CNT_W = $clog2(MAX_COEF + 1),
  localparam int PTR_W = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PLANE_W-1:0] top_plane,
  input  logic [PLANE_W-1:0] low_plane,
  input  logic [CNT_W-1:0]   coef_count,
  output logic               busy,
  output logic [PLANE_W-1:0] req_plane,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_mag,
  output logic               out_sign_vld,
  output logic               out_sign,
  output logic [IDX_W-1:0]   out_index,
  output logic [PLANE_W-1:0] out_plane
);
  import sbd_pkg::*;

  run_state_e         st_q;
  logic [PLANE_W-1:0] plane_q, low_q;
  logic [IDX_W-1:0]   idx_q, last_q;
  logic [WORD_W-1:0]  word_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               have_q, pend_q;

  logic               sig_bit, can_take, launch;
  logic [WORD_W-1:0]  word_sh;
  logic               mag_bit, next_bit, need_sign, at_edge;
  logic               emit_a, emit_b, emit, r_mag, r_sv, r_sgn;
  logic [PTR_W+1:0]   ptr_sum;

  assign launch    = start && (st_q == ST_IDLE);
  assign busy      = (st_q == ST_RUN);
  assign req_plane = plane_q;

  assign word_sh   = word_q >> ptr_q;
  assign mag_bit   = word_sh[0];
  assign next_bit  = word_sh[1];
  assign need_sign = mag_bit && !sig_bit;
  assign at_edge   = (ptr_q == PTR_W'(WORD_W - 1));
  assign ptr_sum   = {2'b00, ptr_q} + (need_sign ? (PTR_W+2)'(2) : (PTR_W+2)'(1));

  assign in_ready = busy && !have_q && (!pend_q || can_take);
  assign emit_a   = busy && have_q && !pend_q && can_take && !(need_sign && at_edge);
  assign emit_b   = busy && pend_q && in_valid && can_take;
  assign emit     = emit_a || emit_b;
  assign r_mag    = emit_b ? 1'b1 : mag_bit;
  assign r_sv     = emit_b ? 1'b1 : need_sign;
  assign r_sgn    = emit_b ? in_word[0] : (need_sign && next_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; plane_q <= '0; low_q <= '0; idx_q <= '0; last_q <= '0;
      word_q <= '0; ptr_q <= '0; have_q <= 1'b0; pend_q <= 1'b0;
    end else if (launch) begin
      st_q    <= ST_RUN;
      plane_q <= top_plane;
      low_q   <= low_plane;
      last_q  <= IDX_W'(coef_count - 1'b1);
      idx_q   <= '0;
      have_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else if (busy) begin
      if (!have_q && !pend_q && in_valid) begin
        word_q <= in_word;
        ptr_q  <= '0;
        have_q <= 1'b1;
      end else if (have_q && !pend_q && need_sign && at_edge) begin
        pend_q <= 1'b1;
        have_q <= 1'b0;
      end
      if (emit_a) begin
        ptr_q <= PTR_W'(ptr_sum);
        if (ptr_sum >= (PTR_W+2)'(WORD_W)) have_q <= 1'b0;
      end
      if (emit_b) begin
        word_q <= in_word;
        ptr_q  <= PTR_W'(1);
        have_q <= 1'b1;
        pend_q <= 1'b0;
      end
      if (emit) begin
        if (idx_q == last_q) begin
          idx_q  <= '0;
          have_q <= 1'b0;
          if (plane_q == low_q) st_q <= ST_IDLE;
          else plane_q <= plane_q - 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  sbd_sig_bits #(.MAX_COEF(MAX_COEF)) u_sig (
    .clk(clk), .rst_n(rst_n), .clr(launch), .set_en(emit && r_sv),
    .set_idx(idx_q), .rd_idx(idx_q), .rd_bit(sig_bit)
  );

  sbd_out_stage #(.PLANE_W(PLANE_W), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .d_mag(r_mag), .d_sv(r_sv),
    .d_sgn(r_sgn), .d_idx(idx_q), .d_plane(plane_q), .can_take(can_take),
    .out_valid(out_valid), .out_ready(out_ready), .out_mag(out_mag),
    .out_sign_vld(out_sign_vld), .out_sign(out_sign), .out_index(out_index),
    .out_plane(out_plane)
  );

  // R11
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);
  // R9
  plane_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (req_plane >= low_q));
  // R2
  plane_descends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (req_plane <= $past(req_plane)));
endmodule

// File: tb/bitplane_sign_parser_test.sv
`timescale 1ns/100ps
module bitplane_sign_parser_test;
  localparam int WW = 8, MC = 64, PW = 4;
  localparam int IW = $clog2(MC), CW = $clog2(MC + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [PW-1:0] top_plane = '0, low_plane = '0;
  logic [CW-1:0] coef_count = CW'(1);
  logic busy, in_ready, out_valid, out_mag, out_sign_vld, out_sign;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [WW-1:0] in_word = '0;
  logic [PW-1:0] req_plane, out_plane;
  logic [IW-1:0] out_index;

  always #2.5 clk = ~clk;

  bitplane_sign_parser #(.WORD_W(WW), .MAX_COEF(MC), .PLANE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .top_plane(top_plane),
    .low_plane(low_plane), .coef_count(coef_count), .busy(busy),
    .req_plane(req_plane), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_mag(out_mag), .out_sign_vld(out_sign_vld), .out_sign(out_sign),
    .out_index(out_index), .out_plane(out_plane)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] cmag [MC];
  logic        cneg [MC];
  logic [WW-1:0] mem [16][20];
  int wlen [16], rptr [16];
  logic e_mag [1024], e_sv [1024], e_sgn [1024];
  int e_idx [1024], e_pl [1024];
  int n_exp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // packs each decoded plane as the requirements describe (R3, R4, R5, R7, R8)
  task automatic build(input int tp, input int lp, input int n);
    for (int p = 0; p < 16; p++) begin
      wlen[p] = 0; rptr[p] = 0;
      for (int k = 0; k < 20; k++) mem[p][k] = '0;
    end
    n_exp = 0;
    for (int p = tp; p >= lp; p--) begin
      int bp = 0;
      for (int i = 0; i < n; i++) begin
        logic b = cmag[i][p];
        mem[p][bp / WW][bp % WW] = b; bp++;
        e_mag[n_exp] = b; e_idx[n_exp] = i; e_pl[n_exp] = p;
        if (b && ((cmag[i] >> (p + 1)) == 0)) begin
          mem[p][bp / WW][bp % WW] = cneg[i]; bp++;
          e_sv[n_exp] = 1'b1; e_sgn[n_exp] = cneg[i];
        end else begin
          e_sv[n_exp] = 1'b0; e_sgn[n_exp] = 1'b0;
        end
        n_exp++;
      end
      wlen[p] = (bp + WW - 1) / WW;
    end
  endtask

  task automatic run_case(input int tp, input int lp, input int n, input bit stall, input string tag);
    int got = 0, cyc = 0;
    bit fi, fo, pstall = 0;
    logic [31:0] pval = '0, cval;
    int fpl;
    build(tp, lp, n);
    @(negedge clk);
    top_plane = PW'(tp); low_plane = PW'(lp); coef_count = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (got < n_exp && cyc < 20000) begin
      in_valid  = stall ? ($urandom % 4 != 0) : 1'b1;
      in_word   = (rptr[req_plane] < 20) ? mem[req_plane][rptr[req_plane]] : '0;
      out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
      #1;
      fi = in_valid && in_ready; fo = out_valid && out_ready;
      fpl = int'(req_plane);
      cval = {out_valid, out_mag, out_sign_vld, out_sign, 8'(out_index), 8'(out_plane)};
      // R10: a stalled result is still there, unchanged, one cycle later
      if (pstall) chk(cval == pval, "R10 hold", int'(cval), int'(pval));
      pstall = out_valid && !out_ready; pval = cval;
      if (fi) begin
        // R9: only planes inside the decoded range, never past their length
        chk(fpl >= lp && fpl <= tp && rptr[fpl] < wlen[fpl], "R9 fetch", fpl, lp);
        rptr[fpl]++;
      end
      if (fo) begin
        chk(int'(out_plane) == e_pl[got] && int'(out_index) == e_idx[got],
            {"R2 order ", tag}, int'(out_plane) * 256 + int'(out_index),
            e_pl[got] * 256 + e_idx[got]);
        chk(out_mag == e_mag[got], {"R3 mag ", tag}, int'(out_mag), int'(e_mag[got]));
        if (e_sv[got])
          chk(out_sign_vld && out_sign == e_sgn[got], {"R4 sign ", tag},
              int'({out_sign_vld, out_sign}), int'({1'b1, e_sgn[got]}));
        else
          chk(!out_sign_vld && !out_sign, {"R5 no sign ", tag},
              int'({out_sign_vld, out_sign}), 0);
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 20000) chk(1'b0, {"watchdog ", tag}, got, n_exp);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid, {"R2 run end ", tag}, int'({busy, out_valid}), 0);
    // R8/R9: every decoded plane consumed exactly its words, others none
    for (int p = 0; p < 16; p++)
      chk(rptr[p] == wlen[p], {"R9 word count ", tag}, rptr[p], wlen[p]);
  endtask

  task automatic fill_rand(input int tp, input int n);
    for (int i = 0; i < MC; i++) begin
      cmag[i] = (i < n) ? 16'($urandom % (1 << (tp + 1))) : 16'h0;
      if ($urandom % 3 == 0) cmag[i] = 16'h0;
      cneg[i] = 1'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !in_ready && !out_valid, "R1 reset", int'({busy, in_ready, out_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: idle block refuses words
    in_valid = 1'b1; #1;
    chk(!in_ready, "R11 idle", int'(in_ready), 0);
    in_valid = 1'b0;
    // R7: coefficient 7 becomes significant at bit 7, sign spills to next word
    for (int i = 0; i < MC; i++) begin cmag[i] = (i == 7 || i == 12) ? 16'h1 : 16'h0; cneg[i] = (i == 7); end
    run_case(0, 0, 16, 1'b0, "R7 edge");
    // single coefficient, single plane
    cmag[0] = 16'h1; cneg[0] = 1'b1;
    run_case(0, 0, 1, 1'b0, "single");
    // all zero, several planes (R8 tail discard)
    for (int i = 0; i < MC; i++) begin cmag[i] = 16'h0; cneg[i] = 1'b0; end
    run_case(5, 2, 13, 1'b1, "zeros");
    // all maximal, all negative: signs only in top plane
    for (int i = 0; i < MC; i++) begin cmag[i] = 16'h00FF; cneg[i] = 1'b1; end
    run_case(7, 0, MC, 1'b0, "full");
    // R6: same data again, significance must be cleared so signs repeat
    run_case(7, 0, MC, 1'b1, "R6 rerun");
    // truncation: only upper planes decoded (R9)
    fill_rand(11, 40);
    run_case(11, 6, 40, 1'b1, "trunc");
    // random mix
    for (int t = 0; t < 25; t++) begin
      int tp = $urandom % 16;
      int lp = $urandom % (tp + 1);
      int n  = 1 + $urandom % MC;
      fill_rand(tp, n);
      run_case(tp, lp, n, 1'($urandom), "random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule